// File: doc/BRIEF.md
# Two-Bus Register Datapath

This block is the register-transfer core of a small microcoded processor. Each cycle a 4-bit source code picks one register to drive the B bus. The B bus feeds the right-hand operand of a 32-bit ALU. The left-hand operand always comes from the holding register `H`, which has no output enable. The ALU result goes through a small shifter onto the C bus. From there a 9-bit write-enable vector stores it into any set of destination registers at the next rising clock edge.

The register set has seven 32-bit working registers (`MAR`, `MDR`, `SP`, `LV`, `CPP`, `TOS`, `OPC`), the 32-bit `H`, an 8-bit program counter `PC` and an 8-bit fetch byte register `MBR`. `MBR` is loaded from a byte input, stands for fetched instruction bytes, and is never a C-bus destination. It reaches the B bus in two forms: sign-extended or zero-extended. Negative and zero flags from the ALU output are held in flip-flops for a sequencer to test in the next cycle.

Top module: `bus_datapath`

## Requirements
- R1: `bsel_i` values 0 to 8 put the following on the B bus, in this order: MDR, PC zero-extended, MBR sign-extended, MBR zero-extended, SP, LV, CPP, TOS, OPC. Values 9 to 15 put all zeros on the B bus.
- R2: At most one source is enabled onto the B bus in any cycle.
- R3: Code 2 presents MBR with bit 7 copied into bits 31..8. Code 3 presents MBR with bits 31..8 cleared.
- R4: The A operand is H when `alu_i[3]` (A enable) is 1, and zero otherwise. `alu_i[1]` inverts the gated A operand. `alu_i[2]` (B enable) gates the B bus in the same way.
- R5: `alu_i[5:4]` selects the function: 00 = A AND B, 01 = A OR B, 10 = NOT B, 11 = A + B + `alu_i[0]`. The sum wraps modulo 2^32.
- R6: The shifter acts on the ALU output. `shift_i[1]` shifts left logically by 8 and `shift_i[0]` shifts right arithmetically by 1. With both bits at 0 the value passes unchanged. The two bits are never 1 together.
- R7: `cwe_i` bits map to H=0, OPC=1, TOS=2, CPP=3, LV=4, SP=5, MDR=6, MAR=7, PC=8. Every register whose bit is 1 captures the same C-bus value at the next rising edge. Every register whose bit is 0 keeps its value.
- R8: PC stores bits 7..0 of the C-bus value.
- R9: `n_o` and `z_o` are registered every cycle from the ALU output, taken before the shifter. `n_o` is bit 31. `z_o` is 1 when all 32 bits are zero.
- R10: While `rst_ni` is low, every register and both flags are zero.
- R11: MBR captures `mbr_din_i` at a rising edge when `mbr_we_i` is 1, and holds its value otherwise.
- R12: A register that is both the B source and a C destination in one cycle supplies its old value to the ALU and takes the new value at the edge. The same holds for H as A operand and destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bsel_i | input | 4 | B-bus source code |
| cwe_i | input | 9 | C-bus write enables, one per destination |
| alu_i | input | 6 | {f1, f0, ena, enb, inva, inc} |
| shift_i | input | 2 | {sll8, sra1} |
| mbr_we_i | input | 1 | Load MBR from byte input |
| mbr_din_i | input | 8 | Fetched byte |
| mar_o | output | 32 | MAR value |
| mdr_o | output | 32 | MDR value |
| pc_o | output | 8 | PC value |
| mbr_o | output | 8 | MBR value |
| sp_o | output | 32 | SP value |
| lv_o | output | 32 | LV value |
| cpp_o | output | 32 | CPP value |
| tos_o | output | 32 | TOS value |
| opc_o | output | 32 | OPC value |
| h_o | output | 32 | H value |
| n_o | output | 1 | Saved negative flag |
| z_o | output | 1 | Saved zero flag |

## Verification
The case that needs care is a register read onto a bus and written back from the C bus in the same cycle. The bench does this with TOS as B source and destination, writing TOS and MAR together with TOS+H. Both must receive the old TOS plus one, and TOS must not be counted twice. It then writes H with H+TOS and checks that the old H was used. The multi-destination write also checks that a register not enabled keeps its value across that edge.

// File: rtl/dp_pkg.sv
package dp_pkg;
  typedef enum logic [3:0] {
    BS_MDR   = 4'd0,
    BS_PC    = 4'd1,
    BS_MBR_S = 4'd2,
    BS_MBR_U = 4'd3,
    BS_SP    = 4'd4,
    BS_LV    = 4'd5,
    BS_CPP   = 4'd6,
    BS_TOS   = 4'd7,
    BS_OPC   = 4'd8
  } bsel_e;

  localparam int unsigned NUM_SRC = 9;
  localparam int unsigned NUM_WE  = 9;

  // C-bus enable indices; PC is last so the full-width bank is contiguous
  localparam int unsigned CW_H   = 0;
  localparam int unsigned CW_OPC = 1;
  localparam int unsigned CW_TOS = 2;
  localparam int unsigned CW_CPP = 3;
  localparam int unsigned CW_LV  = 4;
  localparam int unsigned CW_SP  = 5;
  localparam int unsigned CW_MDR = 6;
  localparam int unsigned CW_MAR = 7;
  localparam int unsigned CW_PC  = 8;

  typedef struct packed {
    logic f1;
    logic f0;
    logic ena;
    logic enb;
    logic inva;
    logic inc;
  } alu_ctrl_t;

  typedef struct packed {
    logic sll8;
    logic sra1;
  } shift_ctrl_t;
endpackage

// File: rtl/dp_bsrc.sv
module dp_bsrc
  import dp_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned BW = 8
) (
  input  logic [3:0]    code_i,
  input  logic [DW-1:0] mdr_i,
  input  logic [BW-1:0] pc_i,
  input  logic [BW-1:0] mbr_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] lv_i,
  input  logic [DW-1:0] cpp_i,
  input  logic [DW-1:0] tos_i,
  input  logic [DW-1:0] opc_i,
  output logic [DW-1:0] bus_o
);
  localparam int unsigned NCODE = 16;
  localparam int unsigned XW    = DW - BW;

  logic [NCODE-1:0] en;
  logic [DW-1:0]    src [NUM_SRC];

  always_comb begin
    en         = '0;
    en[code_i] = 1'b1;
    AST_ONE_SRC: assert ($onehot0(en[NUM_SRC-1:0])); // R2
  end

  assign src[BS_MDR]   = mdr_i;
  assign src[BS_PC]    = {{XW{1'b0}}, pc_i};
  assign src[BS_MBR_S] = {{XW{mbr_i[BW-1]}}, mbr_i};
  assign src[BS_MBR_U] = {{XW{1'b0}}, mbr_i};
  assign src[BS_SP]    = sp_i;
  assign src[BS_LV]    = lv_i;
  assign src[BS_CPP]   = cpp_i;
  assign src[BS_TOS]   = tos_i;
  assign src[BS_OPC]   = opc_i;

  // AND-OR bus: unused codes enable nothing and leave zero
  always_comb begin
    bus_o = '0;
    for (int i = 0; i < NUM_SRC; i++)
      bus_o = bus_o | (src[i] & {DW{en[i]}});
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_ctrl_t     ctrl_i,
  output logic [DW-1:0] y_o
);
  logic [DW-1:0] a_g, b_g;

  always_comb begin
    a_g = ctrl_i.ena ? a_i : '0;
    if (ctrl_i.inva) a_g = ~a_g;
    b_g = ctrl_i.enb ? b_i : '0;
    unique case ({ctrl_i.f1, ctrl_i.f0})
      2'b00:   y_o = a_g & b_g;
      2'b01:   y_o = a_g | b_g;
      2'b10:   y_o = ~b_g;
      default: y_o = a_g + b_g + {{(DW-1){1'b0}}, ctrl_i.inc};
    endcase
  end
endmodule

// File: rtl/dp_shift.sv
module dp_shift
  import dp_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned SLL = 8
) (
  input  logic [DW-1:0] d_i,
  input  shift_ctrl_t   ctrl_i,
  output logic [DW-1:0] q_o
);
  always_comb begin
    if (ctrl_i.sll8)      q_o = {d_i[DW-SLL-1:0], {SLL{1'b0}}};
    else if (ctrl_i.sra1) q_o = {d_i[DW-1], d_i[DW-1:1]};
    else                  q_o = d_i;
  end
endmodule

// File: rtl/bus_datapath.sv
module bus_datapath
  import dp_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    bsel_i,
  input  logic [8:0]    cwe_i,
  input  logic [5:0]    alu_i,
  input  logic [1:0]    shift_i,
  input  logic          mbr_we_i,
  input  logic [7:0]    mbr_din_i,
  output logic [DW-1:0] mar_o,
  output logic [DW-1:0] mdr_o,
  output logic [BW-1:0] pc_o,
  output logic [BW-1:0] mbr_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] lv_o,
  output logic [DW-1:0] cpp_o,
  output logic [DW-1:0] tos_o,
  output logic [DW-1:0] opc_o,
  output logic [DW-1:0] h_o,
  output logic          n_o,
  output logic          z_o
);
  localparam int unsigned NFULL = NUM_WE - 1;

  alu_ctrl_t     alu_c;
  shift_ctrl_t   sh_c;
  logic [DW-1:0] b_bus, alu_y, c_bus;
  logic [DW-1:0] rf [NFULL];
  logic [BW-1:0] pc_q, mbr_q;
  logic          n_q, z_q;

  assign alu_c = alu_ctrl_t'(alu_i);
  assign sh_c  = shift_ctrl_t'(shift_i);

  dp_bsrc #(.DW(DW), .BW(BW)) u_bsrc (
    .code_i (bsel_i),
    .mdr_i  (rf[CW_MDR]),
    .pc_i   (pc_q),
    .mbr_i  (mbr_q),
    .sp_i   (rf[CW_SP]),
    .lv_i   (rf[CW_LV]),
    .cpp_i  (rf[CW_CPP]),
    .tos_i  (rf[CW_TOS]),
    .opc_i  (rf[CW_OPC]),
    .bus_o  (b_bus)
  );

  dp_alu #(.DW(DW)) u_alu (
    .a_i    (rf[CW_H]),
    .b_i    (b_bus),
    .ctrl_i (alu_c),
    .y_o    (alu_y)
  );

  dp_shift #(.DW(DW)) u_shift (
    .d_i    (alu_y),
    .ctrl_i (sh_c),
    .q_o    (c_bus)
  );

  for (genvar g = 0; g < NFULL; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       rf[g] <= '0;
      else if (cwe_i[g]) rf[g] <= c_bus;
    end

    AST_C_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cwe_i[g] |=> rf[g] == $past(c_bus)); // R7
    AST_C_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cwe_i[g] |=> $stable(rf[g])); // R7
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mbr_q <= '0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
    end else begin
      if (cwe_i[CW_PC]) pc_q <= c_bus[BW-1:0];
      if (mbr_we_i)     mbr_q <= mbr_din_i;
      n_q <= alu_y[DW-1];
      z_q <= (alu_y == '0);
    end
  end

  assign h_o   = rf[CW_H];
  assign opc_o = rf[CW_OPC];
  assign tos_o = rf[CW_TOS];
  assign cpp_o = rf[CW_CPP];
  assign lv_o  = rf[CW_LV];
  assign sp_o  = rf[CW_SP];
  assign mdr_o = rf[CW_MDR];
  assign mar_o = rf[CW_MAR];
  assign pc_o  = pc_q;
  assign mbr_o = mbr_q;
  assign n_o   = n_q;
  assign z_o   = z_q;

  AST_UNUSED_SRC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bsel_i > 4'd8) |-> b_bus == '0); // R1
  AST_MBR_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bsel_i == BS_MBR_S) |-> b_bus[DW-1:BW] == {(DW-BW){mbr_q[BW-1]}}); // R3
  AST_SHIFT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_i[1] && shift_i[0])); // R6
  AST_PC_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cwe_i[CW_PC] |=> pc_q == $past(c_bus[BW-1:0])); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(n_q && z_q)); // R9
  AST_MBR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbr_we_i |=> mbr_q == $past(mbr_din_i)); // R11
endmodule

// File: tb/tb_bus_datapath.sv
module tb_bus_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bsel = '0;
  logic [8:0]  cwe = '0;
  logic [5:0]  alu = '0;
  logic [1:0]  shift = '0;
  logic        mbr_we = 1'b0;
  logic [7:0]  mbr_din = '0;
  logic [31:0] mar, mdr, sp, lv, cpp, tos, opc, h;
  logic [7:0]  pc, mbr;
  logic        n, z;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  bus_datapath dut (
    .clk_i(clk), .rst_ni(rst_n), .bsel_i(bsel), .cwe_i(cwe), .alu_i(alu),
    .shift_i(shift), .mbr_we_i(mbr_we), .mbr_din_i(mbr_din),
    .mar_o(mar), .mdr_o(mdr), .pc_o(pc), .mbr_o(mbr), .sp_o(sp), .lv_o(lv),
    .cpp_o(cpp), .tos_o(tos), .opc_o(opc), .h_o(h), .n_o(n), .z_o(z)
  );

  localparam logic [8:0] M_H = 9'h001, M_OPC = 9'h002, M_TOS = 9'h004,
    M_CPP = 9'h008, M_LV = 9'h010, M_SP = 9'h020, M_MDR = 9'h040,
    M_MAR = 9'h080, M_PC = 9'h100;
  // {f1,f0,ena,enb,inva,inc}
  localparam logic [5:0] OP_ZERO = 6'b010000, OP_PASS_A = 6'b011000,
    OP_PASS_B = 6'b010100, OP_OR = 6'b011100, OP_ADD = 6'b111100;

  typedef struct packed {
    logic [31:0] hv;
    logic [31:0] tv;
    logic [5:0]  op;
    logic [1:0]  sh;
    logic [31:0] res;
    logic        en;
    logic        ez;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{32'hF0F0_F0F0, 32'hFF00_FF00, 6'b001100, 2'b00, 32'hF000_F000, 1'b1, 1'b0}, // R5 and
    '{32'h0000_00FF, 32'h1234_0000, 6'b011100, 2'b00, 32'h1234_00FF, 1'b0, 1'b0}, // R5 or
    '{32'h1234_5678, 32'h0000_0000, 6'b100100, 2'b00, 32'hFFFF_FFFF, 1'b1, 1'b0}, // R5 not b
    '{32'h7FFF_FFFF, 32'h0000_0001, 6'b111100, 2'b00, 32'h8000_0000, 1'b1, 1'b0}, // R5 add
    '{32'h0000_0005, 32'h0000_000A, 6'b111101, 2'b00, 32'h0000_0010, 1'b0, 1'b0}, // R5 inc
    '{32'h0000_0003, 32'h0000_0077, 6'b111011, 2'b00, 32'hFFFF_FFFD, 1'b1, 1'b0}, // R4 negate A
    '{32'h0F0F_0F0F, 32'hF0F0_F0F0, 6'b001100, 2'b00, 32'h0000_0000, 1'b0, 1'b1}, // R9 zero
    '{32'h5555_5555, 32'h00AB_CDEF, 6'b010100, 2'b10, 32'hABCD_EF00, 1'b0, 1'b0}, // R6 sll8, R4 ena=0
    '{32'h0000_0000, 32'h8000_0004, 6'b010100, 2'b01, 32'hC000_0002, 1'b1, 1'b0}, // R6 sra1
    '{32'h0000_0000, 32'h0000_0001, 6'b010100, 2'b01, 32'h0000_0000, 1'b0, 1'b0}, // R9 flags pre-shift
    '{32'hFFFF_FFFF, 32'h0000_0001, 6'b111100, 2'b00, 32'h0000_0000, 1'b0, 1'b1}, // R5 wrap
    '{32'h0F0F_0F0F, 32'hFFFF_0000, 6'b001110, 2'b00, 32'hF0F0_0000, 1'b1, 1'b0}  // R4 inva
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  // drive at negedge, return at next negedge after the capturing edge
  task automatic cyc(input logic [3:0] b, input logic [8:0] w, input logic [5:0] a,
                     input logic [1:0] s, input logic mw, input logic [7:0] md);
    bsel = b; cwe = w; alu = a; shift = s; mbr_we = mw; mbr_din = md;
    @(negedge clk);
    cwe = '0; mbr_we = 1'b0; shift = '0;
  endtask

  task automatic load_reg(input logic [8:0] m, input logic [31:0] v);
    cyc(4'd0, M_H, OP_ZERO, 2'b00, 1'b0, 8'h00);
    for (int i = 3; i >= 0; i--) begin
      cyc(4'd0, '0, OP_ZERO, 2'b00, 1'b1, v[i*8 +: 8]);
      cyc(4'd3, M_H, OP_OR, (i > 0) ? 2'b10 : 2'b00, 1'b0, 8'h00);
    end
    if (m != M_H) cyc(4'd0, m, OP_PASS_A, 2'b00, 1'b0, 8'h00);
  endtask

  function automatic logic [31:0] src_exp(input int c);
    case (c)
      0: return 32'h1111_2222;
      1: return 32'h0000_005A;
      2: return 32'hFFFF_FF9C;
      3: return 32'h0000_009C;
      4: return 32'h3333_0001;
      5: return 32'h4444_0002;
      6: return 32'h6666_0003;
      7: return 32'h7777_0004;
      8: return 32'h8888_0005;
      default: return 32'h0;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R10: reset state
    check("R10 h", h, 32'h0);   check("R10 tos", tos, 32'h0);
    check("R10 mar", mar, 32'h0); check("R10 pc", {24'h0, pc}, 32'h0);
    check("R10 mbr", {24'h0, mbr}, 32'h0); check("R10 flags", {30'h0, n, z}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      load_reg(M_TOS, VEC[i].tv);
      load_reg(M_H, VEC[i].hv);
      cyc(4'd7, M_OPC, VEC[i].op, VEC[i].sh, 1'b0, 8'h00);
      check($sformatf("R5 vec %0d result", i), opc, VEC[i].res);
      check($sformatf("R9 vec %0d flags", i), {30'h0, n, z}, {30'h0, VEC[i].en, VEC[i].ez});
    end

    // R1 R3: every source code
    load_reg(M_MDR, 32'h1111_2222);
    load_reg(M_PC,  32'hDEAD_BE5A);
    load_reg(M_SP,  32'h3333_0001);
    load_reg(M_LV,  32'h4444_0002);
    load_reg(M_CPP, 32'h6666_0003);
    load_reg(M_TOS, 32'h7777_0004);
    load_reg(M_OPC, 32'h8888_0005);
    cyc(4'd0, '0, OP_ZERO, 2'b00, 1'b1, 8'h9C);
    check("R11 mbr load", {24'h0, mbr}, 32'h9C);
    for (int c = 0; c < 16; c++) begin
      cyc(4'(c), M_H, OP_PASS_B, 2'b00, 1'b0, 8'h00);
      check($sformatf("R1 code %0d", c), h, src_exp(c));
      if (c == 2) check("R3 sign ext", h, 32'hFFFF_FF9C);
      if (c == 3) check("R3 zero ext", h, 32'h0000_009C);
    end
    check("R1 unused code sets z", {31'h0, z}, 32'h1);

    // R11: no load without enable
    cyc(4'd0, '0, OP_ZERO, 2'b00, 1'b0, 8'hFF);
    check("R11 mbr hold", {24'h0, mbr}, 32'h9C);

    // R12: same register read and written
    load_reg(M_TOS, 32'h0000_0010);
    load_reg(M_H, 32'h0000_0001);
    cyc(4'd7, M_TOS | M_MAR, OP_ADD, 2'b00, 1'b0, 8'h00);
    check("R12 tos", tos, 32'h0000_0011);
    check("R12 mar", mar, 32'h0000_0011);
    cyc(4'd7, M_H, OP_ADD, 2'b00, 1'b0, 8'h00);
    check("R12 h", h, 32'h0000_0012);

    // R7: multi-destination write, others hold
    load_reg(M_H, 32'hCAFE_0001);
    cyc(4'd0, M_SP | M_LV | M_CPP, OP_PASS_A, 2'b00, 1'b0, 8'h00);
    check("R7 sp", sp, 32'hCAFE_0001);
    check("R7 lv", lv, 32'hCAFE_0001);
    check("R7 cpp", cpp, 32'hCAFE_0001);
    check("R7 tos held", tos, 32'h0000_0011);
    check("R7 mdr held", mdr, 32'h1111_2222);

    // R8: pc keeps low byte
    load_reg(M_H, 32'h1234_56A7);
    cyc(4'd0, M_PC, OP_PASS_A, 2'b00, 1'b0, 8'h00);
    check("R8 pc", {24'h0, pc}, 32'h0000_00A7);
    check("R8 mar held", mar, 32'h0000_0011);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule